// File: doc/BRIEF.md
# Multi-Port Word Memory with Per-Port Edge and Read Modes

This block is a word-organised storage array with several independent read ports and several write ports, all sharing one clock. Every port's address, data and enable signals sit side by side in flat buses, so port n always uses slice n of each bus. A write port commits on either the rising or the falling clock edge, as its own parameter bit selects. A write port has one mask bit per data bit, and a fixed rule decides which port wins when ports collide.

A read port is either clocked or combinational. A clocked read port picks its own clock edge and updates only when its enable is high. It is transparent when it returns data written on the same edge, and non-transparent when it returns the contents as they were before that edge. The array loads a parameterised image on reset. Addresses that point past the last word read as zero and cannot be written.

Top module: `mpram`

## Requirements
- R1: While `rst_n` is low, the array takes the contents of `INIT_IMAGE`, where word i sits at bits i*DW upward, and every clocked read output clears to zero.
- R2: Port n uses bits n*AW upward of `rd_addr`/`wr_addr`, bits n*DW upward of `rd_data`/`wr_data`/`wr_mask`, and bit n of `rd_en`.
- R3: A write changes only the data bits whose `wr_mask` bit is 1. Every other bit of the word keeps its value.
- R4: When several write ports write the same bit on the same clock edge, the port with the highest index sets the stored value.
- R5: A write port whose `WR_RISE` bit is 1 commits on the rising edge of `clk`, and one whose bit is 0 commits on the falling edge. A clocked read port chooses its edge in the same way with `RD_RISE`.
- R6: A read port whose `RD_SYNC` bit is 0 shows the word at its address combinationally. It ignores its enable and the clock.
- R7: A clocked read port whose enable is low at its edge keeps its previous output.
- R8: A clocked read port whose `RD_BYPASS` bit is 1 returns the newly written value when it reads a word that is written on its own edge.
- R9: A clocked read port whose `RD_BYPASS` bit is 0 returns the contents as they stood before the writes of its own edge.
- R10: A read from an address of DEPTH or more returns all zeros, and a write to such an address changes no stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock. Each port picks which edge it uses |
| rst_n | input | 1 | Asynchronous active-low reset. Loads the initial image |
| rd_en | input | N_RD | Enable for each read port. Clocked ports only |
| rd_addr | input | N_RD*AW | Flat read addresses |
| rd_data | output | N_RD*DW | Flat read data |
| wr_addr | input | N_WR*AW | Flat write addresses |
| wr_data | input | N_WR*DW | Flat write data |
| wr_mask | input | N_WR*DW | Per-bit write enables |

## Verification
The bench builds the array with 12 words of 8 bits behind a 4-bit address, so addresses 12 to 15 reach the out-of-range case. It uses two rising-edge write ports and one falling-edge write port, which covers same-edge priority and ordering across the two edges. The three read ports are a transparent rising-edge port, a non-transparent falling-edge port and a combinational port, so every same-address collision meets each read behaviour. A non-trivial initial image makes the reset contents visible through the combinational port.

// File: rtl/mpram_pkg.sv
package mpram_pkg;
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_e;
endpackage

// File: rtl/mpram_bank.sv
// One storage bank per clock edge. The logical contents are the XOR of both banks.
module mpram_bank #(
    parameter int DEPTH = 12,
    parameter int DW    = 8,
    parameter int AW    = 4,
    parameter int N_WR  = 3,
    parameter logic [N_WR-1:0] WR_RISE = '1,
    parameter mpram_pkg::edge_e EDGE = mpram_pkg::EDGE_RISE,
    parameter logic [DEPTH*DW-1:0] RESET_IMAGE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DEPTH*DW-1:0] other_q,
    input  logic [N_WR*AW-1:0]  wr_addr,
    input  logic [N_WR*DW-1:0]  wr_data,
    input  logic [N_WR*DW-1:0]  wr_mask,
    output logic [DEPTH*DW-1:0] bank_q,
    output logic [DEPTH*DW-1:0] image_after
);
    localparam int  BITS    = DEPTH * DW;
    localparam int  HI      = N_WR - 1;
    localparam logic MY_EDGE = (EDGE == mpram_pkg::EDGE_RISE);

    typedef struct packed {
        logic [BITS-1:0] bank;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [BITS-1:0] image_now;
    logic            any_live;

    // Ports of this edge are applied in ascending index order, so a higher index wins.
    always_comb begin
        image_now   = st_q.bank ^ other_q;
        image_after = image_now;
        any_live    = 1'b0;
        for (int p = 0; p < N_WR; p++) begin
            int base;
            base = int'(wr_addr[p*AW +: AW]) * DW;
            if (WR_RISE[p] == MY_EDGE && int'(wr_addr[p*AW +: AW]) < DEPTH) begin
                for (int b = 0; b < DW; b++) begin
                    if (wr_mask[p*DW + b]) begin
                        image_after[base + b] = wr_data[p*DW + b];
                        any_live              = 1'b1;
                    end
                end
            end
        end
        st_d.bank = image_after ^ other_q;
    end

    assign bank_q = st_q.bank;

    logic [AW-1:0] hi_addr;
    logic          hi_full;
    assign hi_addr = wr_addr[HI*AW +: AW];
    assign hi_full = (WR_RISE[HI] == MY_EDGE) && (&wr_mask[HI*DW +: DW])
                     && (int'(hi_addr) < DEPTH);

    if (EDGE == mpram_pkg::EDGE_RISE) begin : g_pos
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '{bank: RESET_IMAGE};
            else        st_q <= st_d;
        end
        // R3 as well: with no live mask bit this bank holds.
        p_idle_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !any_live |=> $stable(st_q.bank));
        p_hi_port_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            hi_full |-> (image_after[int'(hi_addr)*DW +: DW] == wr_data[HI*DW +: DW]));
    end else begin : g_neg
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '{bank: RESET_IMAGE};
            else        st_q <= st_d;
        end
        p_idle_bank_r10: assert property (@(negedge clk) disable iff (!rst_n)
            !any_live |=> $stable(st_q.bank));
        p_hi_port_wins_r4: assert property (@(negedge clk) disable iff (!rst_n)
            hi_full |-> (image_after[int'(hi_addr)*DW +: DW] == wr_data[HI*DW +: DW]));
    end
endmodule

// File: rtl/mpram_rd.sv
module mpram_rd #(
    parameter int DEPTH  = 12,
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter bit SYNC   = 1'b1,
    parameter bit RISE   = 1'b1,
    parameter bit BYPASS = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [AW-1:0]       addr,
    input  logic [DEPTH*DW-1:0] image_now,
    input  logic [DEPTH*DW-1:0] image_edge,
    output logic [DW-1:0]       data
);
    localparam int BITS = DEPTH * DW;

    typedef struct packed {
        logic [DW-1:0] word;
    } rd_state_t;

    function automatic logic [DW-1:0] pick(input logic [BITS-1:0] img, input logic [AW-1:0] a);
        pick = '0;
        if (int'(a) < DEPTH) pick = img[int'(a)*DW +: DW];
    endfunction

    logic in_range;
    logic unused_inputs;
    assign in_range      = int'(addr) < DEPTH;
    assign unused_inputs = ^{en, image_edge};

    if (SYNC) begin : g_sync
        rd_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (en) st_d.word = pick(BYPASS ? image_edge : image_now, addr);
        end

        if (RISE) begin : g_pos
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
            p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !en |=> $stable(data));
            p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (en && !in_range) |=> (data == '0));
        end else begin : g_neg
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
            p_hold_r7: assert property (@(negedge clk) disable iff (!rst_n)
                !en |=> $stable(data));
            p_oob_zero_r10: assert property (@(negedge clk) disable iff (!rst_n)
                (en && !in_range) |=> (data == '0));
        end

        assign data = st_q.word;
    end else begin : g_comb
        assign data = pick(image_now, addr);
        p_comb_oob_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !in_range |-> (data == '0));
    end
endmodule

// File: rtl/mpram.sv
module mpram #(
    parameter int DEPTH = 12,
    parameter int DW    = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int N_RD  = 3,
    parameter int N_WR  = 3,
    parameter logic [N_RD-1:0] RD_SYNC   = 3'b011,
    parameter logic [N_RD-1:0] RD_RISE   = 3'b001,
    parameter logic [N_RD-1:0] RD_BYPASS = 3'b001,
    parameter logic [N_WR-1:0] WR_RISE   = 3'b011,
    parameter logic [DEPTH*DW-1:0] INIT_IMAGE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RD-1:0]    rd_en,
    input  logic [N_RD*AW-1:0] rd_addr,
    output logic [N_RD*DW-1:0] rd_data,
    input  logic [N_WR*AW-1:0] wr_addr,
    input  logic [N_WR*DW-1:0] wr_data,
    input  logic [N_WR*DW-1:0] wr_mask
);
    localparam int BITS = DEPTH * DW;

    logic [BITS-1:0] rise_q, fall_q;
    logic [BITS-1:0] rise_after, fall_after;
    logic [BITS-1:0] image_now;

    assign image_now = rise_q ^ fall_q;

    mpram_bank #(
        .DEPTH(DEPTH), .DW(DW), .AW(AW), .N_WR(N_WR), .WR_RISE(WR_RISE),
        .EDGE(mpram_pkg::EDGE_RISE), .RESET_IMAGE(INIT_IMAGE)
    ) u_bank_rise (
        .clk(clk), .rst_n(rst_n), .other_q(fall_q),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
        .bank_q(rise_q), .image_after(rise_after)
    );

    mpram_bank #(
        .DEPTH(DEPTH), .DW(DW), .AW(AW), .N_WR(N_WR), .WR_RISE(WR_RISE),
        .EDGE(mpram_pkg::EDGE_FALL), .RESET_IMAGE('0)
    ) u_bank_fall (
        .clk(clk), .rst_n(rst_n), .other_q(rise_q),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
        .bank_q(fall_q), .image_after(fall_after)
    );

    for (genvar i = 0; i < N_RD; i++) begin : g_rd
        mpram_rd #(
            .DEPTH(DEPTH), .DW(DW), .AW(AW),
            .SYNC(RD_SYNC[i]), .RISE(RD_RISE[i]), .BYPASS(RD_BYPASS[i])
        ) u_rd (
            .clk(clk), .rst_n(rst_n), .en(rd_en[i]),
            .addr(rd_addr[i*AW +: AW]),
            .image_now(image_now),
            .image_edge(RD_RISE[i] ? rise_after : fall_after),
            .data(rd_data[i*DW +: DW])
        );
    end
endmodule

// File: tb/mpram_bench.sv
module mpram_bench;
    localparam int DEPTH = 12;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int NR    = 3;
    localparam int NW    = 3;
    localparam int BITS  = DEPTH * DW;
    localparam logic [NR-1:0] RD_SYNC   = 3'b011;
    localparam logic [NR-1:0] RD_RISE   = 3'b001;
    localparam logic [NR-1:0] RD_BYPASS = 3'b001;
    localparam logic [NW-1:0] WR_RISE   = 3'b011;

    function automatic logic [BITS-1:0] make_init();
        logic [BITS-1:0] v;
        for (int i = 0; i < DEPTH; i++) v[i*DW +: DW] = 8'(i * 37 + 5);
        return v;
    endfunction
    localparam logic [BITS-1:0] INIT = make_init();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NR-1:0]    rd_en   = '0;
    logic [NR*AW-1:0] rd_addr = '0;
    logic [NR*DW-1:0] rd_data;
    logic [NW*AW-1:0] wr_addr = '0;
    logic [NW*DW-1:0] wr_data = '0;
    logic [NW*DW-1:0] wr_mask = '0;

    mpram #(
        .DEPTH(DEPTH), .DW(DW), .AW(AW), .N_RD(NR), .N_WR(NW),
        .RD_SYNC(RD_SYNC), .RD_RISE(RD_RISE), .RD_BYPASS(RD_BYPASS),
        .WR_RISE(WR_RISE), .INIT_IMAGE(INIT)
    ) u_mpram (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask)
    );

    logic [BITS-1:0] model = INIT;
    logic [DW-1:0]   held [NR];
    int n_vec = 0;
    int n_bad = 0;

    function automatic logic [DW-1:0] get(input logic [BITS-1:0] img, input logic [AW-1:0] a);
        if (int'(a) >= DEPTH) return '0;
        return img[int'(a)*DW +: DW];
    endfunction

    function automatic logic [BITS-1:0] put(input logic [BITS-1:0] img, input int p);
        logic [BITS-1:0] r;
        int a;
        r = img;
        a = int'(wr_addr[p*AW +: AW]);
        if (a < DEPTH)
            for (int b = 0; b < DW; b++)
                if (wr_mask[p*DW + b]) r[a*DW + b] = wr_data[p*DW + b];
        return r;
    endfunction

    task automatic check(string tag, int port, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s read port %0d: got %h expected %h", tag, port, got, exp);
        end
    endtask

    task automatic set_wr(int p, int a, logic [DW-1:0] d, logic [DW-1:0] m);
        wr_addr[p*AW +: AW] = AW'(a);
        wr_data[p*DW +: DW] = d;
        wr_mask[p*DW +: DW] = m;
    endtask

    task automatic set_rd(int p, logic e, int a);
        rd_en[p] = e;
        rd_addr[p*AW +: AW] = AW'(a);
    endtask

    task automatic quiet();
        wr_mask = '0;
        rd_en   = '0;
    endtask

    // One full clock: rising-edge ports act first, then falling-edge ports.
    task automatic cycle(string why);
        logic [BITS-1:0] m0, mr, mf;
        logic [DW-1:0] e [NR];
        m0 = model;
        mr = m0;
        for (int p = 0; p < NW; p++) if (WR_RISE[p]) mr = put(mr, p);
        mf = mr;
        for (int p = 0; p < NW; p++) if (!WR_RISE[p]) mf = put(mf, p);
        for (int i = 0; i < NR; i++) begin
            e[i] = held[i];
            if (RD_SYNC[i] && rd_en[i]) begin
                if (RD_RISE[i]) e[i] = RD_BYPASS[i] ? get(mr, rd_addr[i*AW +: AW]) : get(m0, rd_addr[i*AW +: AW]);
                else            e[i] = RD_BYPASS[i] ? get(mf, rd_addr[i*AW +: AW]) : get(mr, rd_addr[i*AW +: AW]);
            end
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        model = mf;
        for (int i = 0; i < NR; i++) begin
            if (RD_SYNC[i]) begin
                held[i] = e[i];
                check(why, i, rd_data[i*DW +: DW], e[i]);
            end else begin
                check(why, i, rd_data[i*DW +: DW], get(model, rd_addr[i*AW +: AW]));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NR; i++) held[i] = '0;
        set_rd(2, 1'b0, 5);
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset contents and cleared clocked outputs
        check("R1", 0, rd_data[0 +: DW], '0);
        check("R1", 1, rd_data[DW +: DW], '0);
        check("R1", 2, rd_data[2*DW +: DW], get(INIT, 4'd5));

        // R3: partial mask on one word
        quiet(); set_wr(0, 3, 8'hFF, 8'h0F); set_rd(0, 1'b1, 3); set_rd(2, 1'b0, 3);
        cycle("R3");
        quiet(); set_wr(1, 3, 8'h00, 8'hC0); set_rd(1, 1'b1, 3); set_rd(2, 1'b0, 3);
        cycle("R3");

        // R4: all write ports on word 7, full mask
        quiet(); set_wr(0, 7, 8'h11, 8'hFF); set_wr(1, 7, 8'h22, 8'hFF); set_wr(2, 7, 8'h33, 8'hFF);
        set_rd(0, 1'b1, 7); set_rd(1, 1'b1, 7); set_rd(2, 1'b0, 7);
        cycle("R4");
        quiet(); set_wr(0, 6, 8'hAA, 8'hFF); set_wr(1, 6, 8'h55, 8'h3C);
        set_rd(0, 1'b1, 6); set_rd(2, 1'b0, 6);
        cycle("R4");

        // R8: transparent rising read sees the rising write
        quiet(); set_wr(1, 2, 8'hA5, 8'hFF); set_rd(0, 1'b1, 2);
        cycle("R8");
        // R9: non-transparent falling read sees the old word
        quiet(); set_wr(2, 9, 8'h3C, 8'hFF); set_rd(1, 1'b1, 9); set_rd(2, 1'b0, 9);
        cycle("R9");
        quiet(); set_rd(1, 1'b1, 9);
        cycle("R9");

        // R5: falling write lands after the rising read of the same cycle
        quiet(); set_wr(2, 4, 8'h5A, 8'hFF); set_rd(0, 1'b1, 4);
        cycle("R5");
        quiet(); set_rd(0, 1'b1, 4); set_rd(1, 1'b1, 4);
        cycle("R5");
        quiet(); set_wr(0, 8, 8'h77, 8'hFF); set_rd(1, 1'b1, 8);
        cycle("R5");

        // R7: enables low, addresses moved, outputs hold
        quiet(); set_rd(0, 1'b0, 1); set_rd(1, 1'b0, 0); set_wr(0, 4, 8'h99, 8'hFF);
        cycle("R7");

        // R6: combinational port follows its address between edges, enable low
        quiet(); set_rd(2, 1'b0, 2);
        #1;
        check("R6", 2, rd_data[2*DW +: DW], get(model, 4'd2));
        set_rd(2, 1'b0, 7);
        #1;
        check("R6", 2, rd_data[2*DW +: DW], get(model, 4'd7));

        // R10: out-of-range reads and writes
        quiet(); set_wr(0, 13, 8'hFF, 8'hFF); set_wr(2, 12, 8'hFF, 8'hFF);
        set_rd(0, 1'b1, 13); set_rd(1, 1'b1, 15); set_rd(2, 1'b0, 12);
        cycle("R10");
        quiet();
        for (int a = 0; a < DEPTH; a++) begin
            set_rd(2, 1'b0, a);
            #1;
            check("R10", 2, rd_data[2*DW +: DW], get(model, AW'(a)));
        end

        // R2: random traffic on every slice of every bus
        for (int k = 0; k < 400; k++) begin
            for (int p = 0; p < NW; p++)
                set_wr(p, int'($urandom_range(15, 0)), DW'($urandom),
                       ($urandom_range(3, 0) == 0) ? '0 : DW'($urandom));
            for (int p = 0; p < NR; p++)
                set_rd(p, 1'($urandom), int'($urandom_range(15, 0)));
            cycle("R2");
        end

        quiet();
        for (int a = 0; a < DEPTH; a++) begin
            set_rd(2, 1'b0, a);
            #1;
            check("R3", 2, rd_data[2*DW +: DW], get(model, AW'(a)));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule